// File: doc/BRIEF.md
# Two-Source Writeback Arbiter

This block sits at the end of a warp-based core pipeline and merges two result sources into one writeback slot. One source is the execute unit, which hands over at most one completed instruction per cycle. The other is the load/store unit, which holds one memory instruction at a time while a fixed memory latency counts down. Each cycle at most one result is granted the slot. The next cycle the slot is presented at the outputs, where the scoreboard marks the destination registers ready again and the warp stall bit is cleared if the release flag is set.

The execute unit always has priority. A load that is ready in a cycle where the execute unit takes the slot is not dropped. It stays in the load/store holding register with a stall flag raised and retries every cycle until it wins. While the load/store unit holds an instruction, including a stalled one, it accepts no new instruction. Stores never use the writeback slot. They leave silently once their latency has expired. Data values and the memory itself are outside this block.

Top module: `wb_arbiter`

## Requirements
- R1: After reset, wb_valid is 0, all writeback fields are 0, lsu_stall is 0 and lsu_ready is 1.
- R2: An execute result captured at a clock edge with exe_rd not 0, or with exe_release set, appears at the next edge on the writeback outputs with its warp, scalar, vector and release fields copied, unless the slot is already taken.
- R3: An execute result with exe_rd equal to 0 and exe_release clear is discarded and never reaches writeback, even when exe_vd is not 0.
- R4: lsu_ready is 1 exactly when the load/store holding register is empty. An instruction is accepted only at an edge where lsu_valid and lsu_ready are both 1, and lsu_ready is 0 while an instruction is held or stalled.
- R5: An accepted load (lsu_store = 0) with lsu_rd or lsu_vd not 0, facing no execute competition, shows wb_valid exactly MEM_LAT+1 edges after its acceptance edge (MEM_LAT defaults to 5).
- R6: An accepted store (lsu_store = 1) never drives wb_valid. The holding register frees itself, and lsu_ready returns, MEM_LAT+1 edges after acceptance.
- R7: A load with both lsu_rd and lsu_vd equal to 0 is discarded like a store when its latency expires.
- R8: When an eligible load and an eligible execute result compete for the same edge, the execute result takes the slot and lsu_stall is 1 from that edge on. The load retries at each later edge and is written back at the first edge with no eligible execute result, and lsu_stall falls at that edge.
- R9: The writeback slot holds a result for one cycle only. When no result is granted, wb_valid is 0 and wb_warp, wb_rd, wb_vd and wb_release are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exe_valid | input | 1 | Execute unit presents a completed instruction |
| exe_warp | input | 3 | Warp of the execute result |
| exe_rd | input | 5 | Scalar destination of the execute result, 0 means none |
| exe_vd | input | 5 | Vector destination of the execute result, 0 means none |
| exe_release | input | 1 | Execute result releases its warp stall bit |
| lsu_valid | input | 1 | Load/store unit offers a new memory instruction |
| lsu_store | input | 1 | 1 for a store, 0 for a load |
| lsu_warp | input | 3 | Warp of the memory instruction |
| lsu_rd | input | 5 | Scalar destination of the load, 0 means none |
| lsu_vd | input | 5 | Vector destination of the load, 0 means none |
| lsu_release | input | 1 | Memory instruction releases its warp stall bit |
| lsu_ready | output | 1 | Holding register empty, a new memory instruction can be accepted |
| lsu_stall | output | 1 | Held load lost arbitration and is waiting |
| wb_valid | output | 1 | Writeback slot holds a result this cycle |
| wb_warp | output | 3 | Warp of the writeback result |
| wb_rd | output | 5 | Scalar register to mark ready |
| wb_vd | output | 5 | Vector register to mark ready |
| wb_release | output | 1 | Clear the stall bit of wb_warp |

## Verification
The bench aims at the edge where a load's latency reaches zero while an execute result is also eligible. A design with the priority reversed would write the load first. A design that drops the loser would never write the load back at all. The bench also counts the exact edge of a load's writeback and a store's departure, which catches an off-by-one latency counter. It checks that stores and destination-less loads free the holding register without a writeback, since a design that got this wrong would emit spurious scoreboard releases or deadlock the load/store unit. Finally, it offers new instructions during a stall, so a design that overwrites a held load shows up as a lost or wrong writeback.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;

    localparam int WB_WARPS = 8;
    localparam int WB_SREGS = 32;
    localparam int WB_VREGS = 32;

    localparam int WARP_W = $clog2(WB_WARPS);
    localparam int SREG_W = $clog2(WB_SREGS);
    localparam int VREG_W = $clog2(WB_VREGS);

    typedef logic [WARP_W-1:0] warp_id_t;
    typedef logic [SREG_W-1:0] sreg_idx_t;
    typedef logic [VREG_W-1:0] vreg_idx_t;

    typedef struct packed {
        logic      valid;
        logic      is_store;
        warp_id_t  warp;
        sreg_idx_t rd;
        vreg_idx_t vd;
        logic      rel_warp;
    } wb_rec_t;

    localparam wb_rec_t WB_REC_EMPTY = '0;

    // An execute result needs the slot if it writes a scalar or frees a warp.
    function automatic logic exe_wants_slot(wb_rec_t r);
        return r.valid && ((r.rd != '0) || r.rel_warp);
    endfunction

    // A load needs the slot only if it names some destination.
    function automatic logic load_has_dest(wb_rec_t r);
        return (r.rd != '0) || (r.vd != '0);
    endfunction

endpackage

// File: rtl/wbarb_rec_reg.sv
module wbarb_rec_reg
    import wbarb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wb_rec_t d,
    output wb_rec_t q
);
    wb_rec_t q_r;

    always_ff @(posedge clk) begin
        if (rst) q_r <= WB_REC_EMPTY;
        else     q_r <= d.valid ? d : WB_REC_EMPTY;
    end

    assign q = q_r;

    // R9
    empty_rec_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !q_r.valid |-> (q_r == WB_REC_EMPTY));
endmodule

// File: rtl/wbarb_lsu_slot.sv
module wbarb_lsu_slot
    import wbarb_pkg::*;
#(
    parameter int MEM_LAT = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  wb_rec_t in_rec,
    input  logic    grant,
    input  logic    lost,
    output logic    ready,
    output logic    load_req,
    output logic    stall,
    output wb_rec_t head
);
    localparam int CNT_W = $clog2(MEM_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MEM_LAT);

    wb_rec_t          head_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stall_q;
    logic             expired, drop, leave, accept;

    assign expired  = head_q.valid && (cnt_q == '0);
    assign load_req = expired && !head_q.is_store && load_has_dest(head_q);
    assign drop     = expired && !load_req;
    assign leave    = drop || (load_req && grant);
    assign ready    = !head_q.valid;
    assign accept   = in_rec.valid && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= WB_REC_EMPTY;
            cnt_q  <= '0;
        end else if (accept) begin
            head_q <= in_rec;
            cnt_q  <= CNT_LOAD;
        end else if (leave) begin
            head_q <= WB_REC_EMPTY;
            cnt_q  <= '0;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  stall_q <= 1'b0;
        else if (leave)           stall_q <= 1'b0;
        else if (load_req && lost) stall_q <= 1'b1;
    end

    assign stall = stall_q;
    assign head  = head_q;

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LOAD);

    // R4
    stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
        stall_q |-> head_q.valid);

    // R4
    accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);
endmodule

// File: rtl/wbarb_select.sv
module wbarb_select
    import wbarb_pkg::*;
(
    input  wb_rec_t exe_rec,
    input  wb_rec_t lsu_rec,
    input  logic    load_req,
    output logic    exe_go,
    output logic    lsu_grant,
    output logic    lsu_lost,
    output wb_rec_t wb_next
);
    always_comb begin
        exe_go    = exe_wants_slot(exe_rec);
        lsu_grant = load_req && !exe_go;
        lsu_lost  = load_req && exe_go;
        if (exe_go)         wb_next = exe_rec;
        else if (lsu_grant) wb_next = lsu_rec;
        else                wb_next = WB_REC_EMPTY;
    end
endmodule

// File: rtl/wb_arbiter.sv
module wb_arbiter
    import wbarb_pkg::*;
#(
    parameter int MEM_LAT = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                exe_valid,
    input  logic [WARP_W-1:0]   exe_warp,
    input  logic [SREG_W-1:0]   exe_rd,
    input  logic [VREG_W-1:0]   exe_vd,
    input  logic                exe_release,
    input  logic                lsu_valid,
    input  logic                lsu_store,
    input  logic [WARP_W-1:0]   lsu_warp,
    input  logic [SREG_W-1:0]   lsu_rd,
    input  logic [VREG_W-1:0]   lsu_vd,
    input  logic                lsu_release,
    output logic                lsu_ready,
    output logic                lsu_stall,
    output logic                wb_valid,
    output logic [WARP_W-1:0]   wb_warp,
    output logic [SREG_W-1:0]   wb_rd,
    output logic [VREG_W-1:0]   wb_vd,
    output logic                wb_release
);
    wb_rec_t exe_in, lsu_in, exe_q, lsu_head, wb_next, wb_q;
    logic    load_req, exe_go, lsu_grant, lsu_lost;

    always_comb begin
        exe_in          = WB_REC_EMPTY;
        exe_in.valid    = exe_valid;
        exe_in.warp     = exe_warp;
        exe_in.rd       = exe_rd;
        exe_in.vd       = exe_vd;
        exe_in.rel_warp = exe_release;

        lsu_in          = WB_REC_EMPTY;
        lsu_in.valid    = lsu_valid;
        lsu_in.is_store = lsu_store;
        lsu_in.warp     = lsu_warp;
        lsu_in.rd       = lsu_rd;
        lsu_in.vd       = lsu_vd;
        lsu_in.rel_warp = lsu_release;
    end

    wbarb_rec_reg u_exe_slot (
        .clk (clk),
        .rst (rst),
        .d   (exe_in),
        .q   (exe_q)
    );

    wbarb_lsu_slot #(.MEM_LAT(MEM_LAT)) u_lsu_slot (
        .clk      (clk),
        .rst      (rst),
        .in_rec   (lsu_in),
        .grant    (lsu_grant),
        .lost     (lsu_lost),
        .ready    (lsu_ready),
        .load_req (load_req),
        .stall    (lsu_stall),
        .head     (lsu_head)
    );

    wbarb_select u_select (
        .exe_rec   (exe_q),
        .lsu_rec   (lsu_head),
        .load_req  (load_req),
        .exe_go    (exe_go),
        .lsu_grant (lsu_grant),
        .lsu_lost  (lsu_lost),
        .wb_next   (wb_next)
    );

    wbarb_rec_reg u_wb_slot (
        .clk (clk),
        .rst (rst),
        .d   (wb_next),
        .q   (wb_q)
    );

    assign wb_valid   = wb_q.valid;
    assign wb_warp    = wb_q.warp;
    assign wb_rd      = wb_q.rd;
    assign wb_vd      = wb_q.vd;
    assign wb_release = wb_q.rel_warp;

    // R8
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exe_go, lsu_grant}));

    // R8
    stall_rise_wb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lsu_stall) |-> wb_valid);

    // R6
    no_store_wb_chk: assert property (@(posedge clk) disable iff (rst)
        wb_q.valid |-> !wb_q.is_store);

    // R4
    stall_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        lsu_stall |-> !lsu_ready);
endmodule

// File: tb/wb_arbiter_tb_top.sv
module wb_arbiter_tb_top;
    import wbarb_pkg::*;

    localparam int LAT = 5;

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic              exe_v, exe_rel, lsu_v, lsu_st, lsu_rel;
    logic [WARP_W-1:0] exe_w, lsu_w;
    logic [SREG_W-1:0] exe_r, lsu_r;
    logic [VREG_W-1:0] exe_vv, lsu_vv;
    logic              lsu_ready, lsu_stall, wb_valid, wb_release;
    logic [WARP_W-1:0] wb_warp;
    logic [SREG_W-1:0] wb_rd;
    logic [VREG_W-1:0] wb_vd;

    wb_arbiter #(.MEM_LAT(LAT)) dut_i (
        .clk(clk), .rst(rst),
        .exe_valid(exe_v), .exe_warp(exe_w), .exe_rd(exe_r), .exe_vd(exe_vv),
        .exe_release(exe_rel),
        .lsu_valid(lsu_v), .lsu_store(lsu_st), .lsu_warp(lsu_w), .lsu_rd(lsu_r),
        .lsu_vd(lsu_vv), .lsu_release(lsu_rel),
        .lsu_ready(lsu_ready), .lsu_stall(lsu_stall),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_rd(wb_rd), .wb_vd(wb_vd),
        .wb_release(wb_release)
    );

    int errors = 0;
    int checks = 0;

    // reference state, built from the requirements
    logic m_ev, m_erel;
    logic [WARP_W-1:0] m_ew;
    logic [SREG_W-1:0] m_er;
    logic [VREG_W-1:0] m_evd;
    logic m_lv, m_lst, m_lrel, m_stall;
    logic [WARP_W-1:0] m_lw;
    logic [SREG_W-1:0] m_lr;
    logic [VREG_W-1:0] m_lvd;
    int   m_cnt;
    logic m_wv, m_wrel;
    logic [WARP_W-1:0] m_ww;
    logic [SREG_W-1:0] m_wr;
    logic [VREG_W-1:0] m_wvd;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ev = 0; m_erel = 0; m_ew = '0; m_er = '0; m_evd = '0;
        m_lv = 0; m_lst = 0; m_lrel = 0; m_lw = '0; m_lr = '0; m_lvd = '0;
        m_cnt = 0; m_stall = 0;
        m_wv = 0; m_wrel = 0; m_ww = '0; m_wr = '0; m_wvd = '0;
    endtask

    task automatic model_step(bit acc);
        bit exe_ok, done, load_ok, gl;
        exe_ok  = m_ev && (m_er != 0 || m_erel);
        done    = m_lv && m_cnt == 0;
        load_ok = done && !m_lst && (m_lr != 0 || m_lvd != 0);
        gl      = load_ok && !exe_ok;
        if (exe_ok) begin
            m_wv = 1; m_ww = m_ew; m_wr = m_er; m_wvd = m_evd; m_wrel = m_erel;
        end else if (gl) begin
            m_wv = 1; m_ww = m_lw; m_wr = m_lr; m_wvd = m_lvd; m_wrel = m_lrel;
        end else begin
            m_wv = 0; m_ww = '0; m_wr = '0; m_wvd = '0; m_wrel = 0;
        end
        if (gl || (done && !load_ok)) m_stall = 0;
        else if (load_ok && exe_ok)   m_stall = 1;
        if (acc) begin
            m_lv = 1; m_lst = lsu_st; m_lw = lsu_w; m_lr = lsu_r; m_lvd = lsu_vv;
            m_lrel = lsu_rel; m_cnt = LAT;
        end else if (gl || (done && !load_ok)) begin
            m_lv = 0; m_cnt = 0;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end
        m_ev = exe_v; m_ew = exe_w; m_er = exe_r; m_evd = exe_vv; m_erel = exe_rel;
    endtask

    task automatic compare();
        chk(wb_valid == m_wv, "R9", "wb_valid", wb_valid, m_wv);
        chk(wb_warp == m_ww && wb_rd == m_wr && wb_vd == m_wvd && wb_release == m_wrel,
            "R2", "wb fields {warp,rd,vd,rel}",
            {wb_warp, wb_rd, wb_vd, wb_release}, {m_ww, m_wr, m_wvd, m_wrel});
        chk(lsu_ready == !m_lv, "R4", "lsu_ready", lsu_ready, !m_lv);
        chk(lsu_stall == m_stall, "R8", "lsu_stall", lsu_stall, m_stall);
    endtask

    task automatic tick();
        bit acc;
        acc = lsu_v && !m_lv;
        @(posedge clk);
        model_step(acc);
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        exe_v = 0; exe_w = '0; exe_r = '0; exe_vv = '0; exe_rel = 0;
        lsu_v = 0; lsu_st = 0; lsu_w = '0; lsu_r = '0; lsu_vv = '0; lsu_rel = 0;
    endtask

    task automatic put_exe(int w, int r, int v, bit rel);
        exe_v = 1; exe_w = WARP_W'(w); exe_r = SREG_W'(r); exe_vv = VREG_W'(v); exe_rel = rel;
    endtask

    task automatic put_lsu(bit st, int w, int r, int v, bit rel);
        lsu_v = 1; lsu_st = st; lsu_w = WARP_W'(w); lsu_r = SREG_W'(r);
        lsu_vv = VREG_W'(v); lsu_rel = rel;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_0042));
        idle();
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(!wb_valid && wb_rd == 0 && wb_vd == 0 && wb_warp == 0 && !wb_release,
            "R1", "wb after reset", wb_valid, 0);
        chk(lsu_ready && !lsu_stall, "R1", "lsu ready/stall after reset",
            {lsu_ready, lsu_stall}, 2);

        // R2 scalar execute result
        put_exe(2, 7, 0, 0); tick(); idle();
        chk(!wb_valid, "R2", "wb before second edge", wb_valid, 0);
        tick();
        chk(wb_valid && wb_rd == 7 && wb_warp == 2, "R2", "exe rd=7 writeback", wb_rd, 7);
        tick();
        chk(!wb_valid, "R9", "slot empties after one cycle", wb_valid, 0);

        // R2 release-only execute result, R3 vector-only dropped
        put_exe(5, 0, 0, 1); tick();
        put_exe(3, 0, 9, 0); tick(); idle();
        chk(wb_valid && wb_release && wb_warp == 5, "R2", "release-only writeback",
            wb_release, 1);
        tick();
        chk(!wb_valid, "R3", "exe rd=0 no release dropped", wb_valid, 0);

        // R5 load latency
        put_lsu(0, 1, 4, 6, 1); tick(); idle();
        chk(!lsu_ready, "R4", "ready low while holding", lsu_ready, 0);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            tick(); n++;
            if (wb_valid) break;
        end
        chk(n == LAT + 1, "R5", "load writeback edge", n, LAT + 1);
        chk(wb_rd == 4 && wb_vd == 6 && wb_release, "R5", "load fields", wb_vd, 6);

        // R6 store frees silently
        put_lsu(1, 2, 3, 0, 0); tick(); idle();
        n = 0;
        for (int i = 0; i < 20; i++) begin
            tick(); n++;
            chk(!wb_valid, "R6", "store on writeback", wb_valid, 0);
            if (lsu_ready) break;
        end
        chk(n == LAT + 1, "R6", "store release edge", n, LAT + 1);

        // R7 load with no destination
        put_lsu(0, 6, 0, 0, 1); tick(); idle();
        n = 0;
        for (int i = 0; i < LAT + 3; i++) begin
            tick();
            if (wb_valid) n++;
        end
        chk(n == 0 && lsu_ready, "R7", "no-dest load writebacks", n, 0);

        // R8 contention: execute wins, load stalls then retires
        put_lsu(0, 4, 11, 0, 0); tick(); lsu_v = 0;
        repeat (LAT - 1) tick();
        put_exe(0, 20, 0, 0); tick();
        put_exe(0, 21, 0, 0); tick();
        put_lsu(0, 7, 13, 0, 0);
        put_exe(0, 22, 0, 0); tick();
        idle(); tick();
        chk(lsu_stall && wb_rd == 22, "R8", "exe wins while load waits", wb_rd, 22);
        chk(!lsu_ready, "R4", "no accept during stall", lsu_ready, 0);
        tick();
        chk(wb_valid && wb_rd == 11 && wb_warp == 4, "R8", "stalled load retires", wb_rd, 11);
        chk(!lsu_stall, "R8", "stall clears on grant", lsu_stall, 0);
        repeat (LAT + 2) tick();

        // random traffic against the reference
        for (int i = 0; i < 4000; i++) begin
            idle();
            if ($urandom_range(1, 0) == 1)
                put_exe($urandom_range(7, 0),
                        ($urandom_range(3, 0) == 0) ? 0 : $urandom_range(31, 1),
                        $urandom_range(31, 0), $urandom_range(4, 0) == 0);
            if ($urandom_range(4, 0) < 2)
                put_lsu($urandom_range(9, 0) < 3, $urandom_range(7, 0),
                        ($urandom_range(2, 0) == 0) ? 0 : $urandom_range(31, 1),
                        ($urandom_range(1, 0) == 0) ? 0 : $urandom_range(31, 1),
                        $urandom_range(4, 0) == 0);
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule